// File: doc/BRIEF.md
# Float32 to Packed 11-11-10 Small-Float Encoder

This block turns three single-precision colour channels into one 32-bit word. The word holds two unsigned 11-bit small floats and one unsigned 10-bit small float. Each channel is re-biased from the 8-bit float32 exponent to a 5-bit exponent with bias 15. Its mantissa is cut down by dropping low bits, so rounding is toward zero. Values that do not fit saturate to the largest finite code. Negative values, infinities and NaNs follow fixed rules, because the packed format carries no sign.

A producer presents the three channels with a valid strobe. One clock later the packed word appears with its own valid strobe. The three channel encoders work side by side and independently. Their codes are ORed into disjoint bit fields.

Top module: `tri_smallfloat_packer`

## Requirements
- R1: Red is encoded with 6 mantissa bits and 5 exponent bits in out_word[10:0], green with the same layout in out_word[21:11], and blue with 5 mantissa bits and 5 exponent bits in out_word[31:22]; inside each field the mantissa occupies the low bits and the exponent sits directly above it.
- R2: A positive finite input with float32 exponent e in 113..142 encodes with small exponent e-112 and with the top mantissa bits of the input, the lower input mantissa bits being discarded.
- R3: A positive finite input with e in 143..254 encodes as the largest finite code: exponent 30 with an all-ones mantissa (red/green 0x7BF, blue 0x3DF), never as infinity.
- R4: Any negative finite input, including negative zero and negative denormals, encodes as zero.
- R5: Positive infinity encodes as exponent 31 with a zero mantissa (red/green 0x7C0, blue 0x3E0); negative infinity encodes as zero.
- R6: A NaN of either sign and any payload encodes as exponent 31 with only the top mantissa bit set (red/green 0x7E0, blue 0x3F0).
- R7: A positive input with e in 1..112 encodes as a small-float denormal: exponent 0 and mantissa floor(value x 2^(14+M)), M being the channel's mantissa width, which reaches zero when the value is too small.
- R8: Positive zero and positive float32 denormals (e equal to 0) encode as zero.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high, out_word carries that input's code in that same cycle, and out_word holds its value while in_valid is low, whatever the channel inputs do.
- R10: While rst is high and after its release, out_valid is 0 and out_word is 0 until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the three channel inputs |
| in_red | input | 32 | Red channel, IEEE single precision |
| in_green | input | 32 | Green channel, IEEE single precision |
| in_blue | input | 32 | Blue channel, IEEE single precision |
| out_valid | output | 1 | Packed word valid, one cycle after in_valid |
| out_word | output | 32 | Packed small-float word |

## Verification
Two different special-case paths can be active in the same cycle, one per channel. Examples are a saturating red beside a NaN green and a denormal blue, or negative infinity beside positive infinity. A fault in the field placement or in the OR combine then corrupts a neighbouring field. The bench drives such mixed words on back-to-back cycles and mixes them with random exponent bands per channel. It compares each whole packed word against a model written from the requirements. It also checks that the word holds during gaps, while the channel inputs are driven with garbage.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int F32_W      = 32;
    localparam int F32_EXP_W  = 8;
    localparam int F32_MANT_W = 23;
    localparam int F32_BIAS   = 127;
    localparam int NUM_CHAN   = 3;

    typedef struct packed {
        logic                  sign;
        logic [F32_EXP_W-1:0]  expo;
        logic [F32_MANT_W-1:0] mant;
    } f32_fields_t;

    typedef enum logic [2:0] {
        SFC_ZERO    = 3'd0,
        SFC_NEG_FIN = 3'd1,
        SFC_POS_FIN = 3'd2,
        SFC_POS_INF = 3'd3,
        SFC_NEG_INF = 3'd4,
        SFC_NAN     = 3'd5
    } sf_class_e;

    function automatic int chan_mant_w(input int idx, input int r_mw, input int g_mw, input int b_mw);
        case (idx)
            0:       return r_mw;
            1:       return g_mw;
            default: return b_mw;
        endcase
    endfunction

    function automatic int chan_lsb(input int idx, input int r_mw, input int g_mw, input int b_mw,
                                    input int ew);
        case (idx)
            0:       return 0;
            1:       return r_mw + ew;
            default: return r_mw + g_mw + 2 * ew;
        endcase
    endfunction

endpackage

// File: rtl/sfp_classifier.sv
module sfp_classifier
    import sfp_pkg::*;
(
    input  logic [F32_W-1:0] f_in,
    output f32_fields_t      fields,
    output sf_class_e        cls
);
    localparam logic [F32_EXP_W-1:0] EXP_ONES = '1;

    always_comb begin
        fields = f32_fields_t'(f_in);
        if (fields.expo == EXP_ONES) begin
            if (fields.mant != '0)
                cls = SFC_NAN;
            else if (fields.sign)
                cls = SFC_NEG_INF;
            else
                cls = SFC_POS_INF;
        end else if (fields.sign) begin
            cls = SFC_NEG_FIN;
        end else if (fields.expo == '0) begin
            cls = SFC_ZERO;
        end else begin
            cls = SFC_POS_FIN;
        end
    end
endmodule

// File: rtl/sfp_channel_enc.sv
module sfp_channel_enc
    import sfp_pkg::*;
#(
    parameter int MANT_W = 6,
    parameter int EXP_W  = 5
) (
    input  logic [F32_W-1:0]        f_in,
    output logic [MANT_W+EXP_W-1:0] code
);
    localparam int CODE_W   = MANT_W + EXP_W;
    localparam int SF_BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int REBIAS   = F32_BIAS - SF_BIAS;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int NORM_TOP = REBIAS + EXP_MAX - 1;
    localparam int DEN_BASE = REBIAS + 1 + (F32_MANT_W - MANT_W);

    localparam logic [CODE_W-1:0] INF_CODE = CODE_W'(EXP_MAX << MANT_W);
    localparam logic [CODE_W-1:0] NAN_CODE = CODE_W'((EXP_MAX << MANT_W) | (1 << (MANT_W - 1)));
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(((EXP_MAX - 1) << MANT_W) | ((1 << MANT_W) - 1));

    f32_fields_t fld;
    sf_class_e   cls;

    sfp_classifier u_cls (
        .f_in   (f_in),
        .fields (fld),
        .cls    (cls)
    );

    logic [F32_EXP_W-1:0]  exp_rb;
    logic [F32_EXP_W-1:0]  den_sh;
    logic [F32_MANT_W:0]   den_val;
    logic [CODE_W-1:0]     fin_code;

    // Finite positive path: saturate, re-bias or denormalise.
    always_comb begin
        exp_rb  = fld.expo - F32_EXP_W'(REBIAS);
        den_sh  = F32_EXP_W'(DEN_BASE) - fld.expo;
        den_val = {1'b1, fld.mant} >> den_sh;
        if (fld.expo > F32_EXP_W'(NORM_TOP))
            fin_code = MAX_CODE;
        else if (fld.expo > F32_EXP_W'(REBIAS))
            fin_code = {exp_rb[EXP_W-1:0], fld.mant[F32_MANT_W-1 -: MANT_W]};
        else
            fin_code = {{EXP_W{1'b0}}, den_val[MANT_W-1:0]};
    end

    always_comb begin
        case (cls)
            SFC_NAN:     code = NAN_CODE;
            SFC_POS_INF: code = INF_CODE;
            SFC_POS_FIN: code = fin_code;
            default:     code = '0;
        endcase
    end
endmodule

// File: rtl/sfp_out_stage.sv
module sfp_out_stage
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [F32_W-1:0] word_d,
    output logic             vld_q,
    output logic [F32_W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            vld_q <= take;
            if (take)
                word_q <= word_d;
        end
    end
endmodule

// File: rtl/tri_smallfloat_packer.sv
module tri_smallfloat_packer
    import sfp_pkg::*;
#(
    parameter int R_MANT_W = 6,
    parameter int G_MANT_W = 6,
    parameter int B_MANT_W = 5,
    parameter int SF_EXP_W = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_red,
    input  logic [31:0] in_green,
    input  logic [31:0] in_blue,
    output logic        out_valid,
    output logic [31:0] out_word
);
    logic [F32_W-1:0] chan_in [NUM_CHAN];
    logic [F32_W-1:0] placed  [NUM_CHAN];
    logic [F32_W-1:0] packed_word;

    assign chan_in[0] = in_red;
    assign chan_in[1] = in_green;
    assign chan_in[2] = in_blue;

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
        localparam int MW  = chan_mant_w(i, R_MANT_W, G_MANT_W, B_MANT_W);
        localparam int LSB = chan_lsb(i, R_MANT_W, G_MANT_W, B_MANT_W, SF_EXP_W);
        localparam int CW  = MW + SF_EXP_W;

        logic [CW-1:0] code;

        sfp_channel_enc #(
            .MANT_W (MW),
            .EXP_W  (SF_EXP_W)
        ) u_enc (
            .f_in (chan_in[i]),
            .code (code)
        );

        assign placed[i] = F32_W'(code) << LSB;
    end

    always_comb begin
        packed_word = '0;
        for (int i = 0; i < NUM_CHAN; i++)
            packed_word = packed_word | placed[i];
    end

    sfp_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .take   (in_valid),
        .word_d (packed_word),
        .vld_q  (out_valid),
        .word_q (out_word)
    );
endmodule

// File: rtl/tri_smallfloat_packer_chk.sv
module tri_smallfloat_packer_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_red,
    input logic [31:0] in_green,
    input logic [31:0] in_blue,
    input logic        out_valid,
    input logic [31:0] out_word
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
    p_nan_red_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_red[30:23] == 8'hFF && in_red[22:0] != 23'd0) |=> out_word[10:0] == 11'h7E0);
    p_nan_blue_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_blue[30:23] == 8'hFF && in_blue[22:0] != 23'd0) |=> out_word[31:22] == 10'h3F0);
    p_neg_green_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_green[31] && in_green[30:23] != 8'hFF) |=> out_word[21:11] == 11'd0);
    p_sat_blue_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_blue[31] && in_blue[30:23] >= 8'd143 && in_blue[30:23] != 8'hFF)
        |=> out_word[31:22] == 10'h3DF);
    p_sat_red_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_red[31] && in_red[30:23] >= 8'd143 && in_red[30:23] != 8'hFF)
        |=> out_word[10:0] == 11'h7BF);
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == 32'd0));
endmodule

bind tri_smallfloat_packer tri_smallfloat_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_red    (in_red),
    .in_green  (in_green),
    .in_blue   (in_blue),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/tri_smallfloat_packer_bench.sv
module tri_smallfloat_packer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_red = '0, in_green = '0, in_blue = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_seen = '0;
    bit          started = 0;

    always #5 clk = ~clk;

    tri_smallfloat_packer u_tri_smallfloat_packer (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .in_red (in_red), .in_green (in_green), .in_blue (in_blue),
        .out_valid (out_valid), .out_word (out_word)
    );

    // Reference from the requirements (R2..R8), mw = mantissa width.
    function automatic int unsigned ref_chan(input logic [31:0] f, input int mw);
        int unsigned e = f[30:23];
        int unsigned m = f[22:0];
        longint unsigned num;
        int sh;
        if (e == 255) begin
            if (m != 0) return (31 << mw) | (1 << (mw - 1));  // R6
            return f[31] ? 0 : (31 << mw);                    // R5
        end
        if (f[31]) return 0;                                  // R4
        if (e == 0) return 0;                                 // R8
        if (e >= 143) return (30 << mw) | ((1 << mw) - 1);    // R3
        if (e >= 113) return ((e - 112) << mw) | (m >> (23 - mw)); // R2
        num = longint'({1'b1, f[22:0]}) << (mw + 14);         // R7
        sh  = 150 - int'(e);
        if (sh > 62) return 0;
        return int'(num >> sh);
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] r, g, b);
        return ref_chan(r, 6) | (ref_chan(g, 6) << 11) | (ref_chan(b, 5) << 22); // R1
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] r, g, b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_red = r; in_green = g; in_blue = b;
        exp_q.push_back(ref_word(r, g, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_red = $urandom; in_green = $urandom; in_blue = $urandom;
        end
    endtask

    function automatic logic [31:0] rand_float();
        logic [7:0] e;
        case ($urandom_range(0, 7))
            0: e = 8'd0;
            1: e = 8'($urandom_range(1, 105));
            2: e = 8'($urandom_range(106, 112));
            3, 4: e = 8'($urandom_range(113, 142));
            5: e = 8'($urandom_range(143, 254));
            6: e = 8'hFF;
            default: e = 8'($urandom_range(100, 150));
        endcase
        return {1'($urandom_range(0, 3) == 0), e, 23'($urandom)};
    endfunction

    // Monitor: pop and compare; R9 hold check in gaps.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), out_word, exp_q.pop_front());
                end
                last_seen = out_word;
                started = 1;
            end else if (started) begin
                check("R9 hold while idle", out_word, last_seen);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", {31'd0, out_valid}, 32'd0);
        check("R10 reset word", out_word, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R10 after release", {31'd0, out_valid} | out_word, 32'd0);

        push(32'h3F800000, 32'h3F800000, 32'h3F800000, "R1 R2 ones");
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R1 R2 hardcoded 1.0 word", out_word, 32'h781E03C0);
        push(32'h477FFFFF, 32'h47800000, 32'h7F7FFFFF, "R2 R3 top normal and saturation");
        push(32'h7FC00001, 32'hFF800001, 32'h7F800000, "R6 R5 NaN and +inf");
        push(32'hFF800000, 32'h80000000, 32'h80123456, "R4 R5 -inf -0 neg denorm");
        push(32'h38000000, 32'h35800000, 32'h35000000, "R7 denormal edges");
        push(32'h387FFFFF, 32'h00400000, 32'h00000000, "R7 R8 e112 and f32 denorm");
        push(32'h7F7FFFFF, 32'h7FFFFFFF, 32'h1C800000, "R3 R6 R7 mixed channels");
        push(32'h38800000, 32'h387FFFFF, 32'h38800001, "R2 R7 normal boundary");
        push(32'hC2C80000, 32'h42C80000, 32'h3E2AAAAB, "R2 R4 mixed sign");
        idle(3);
        for (int i = 0; i < 400; i++) begin
            push(rand_float(), rand_float(), rand_float(), "R1-mix random");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check("R9 all outputs delivered", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule